// File: doc/BRIEF.md
# Power-On Checkpoint Display Sequencer

This block watches a simple write-strobe I/O bus for byte writes to port address 80h and keeps the most recent byte on two seven-segment hex digits. A technician reads the digits to see the last start-up test that was reached. The value stays on the digits until another matching write arrives.

For memory faults, the firmware presents a checkpoint code on the data bus together with a 16-bit map of the failing lines, and pulses a separate fault-load strobe. Only the codes 2Ch, 2Eh and 30h qualify. The block then latches both and enters a locked fault mode. In that mode it rotates the display through three views without end: the checkpoint code, then the upper byte of the map, then the lower byte. Each view is held for a parameterised number of clock cycles. Only a reset leaves fault mode.

Top module: `post_code_display`

## Requirements
- R1: While reset is high, and after it falls, both digits show 0, `view_idx` is 0 and the block is in normal mode.
- R2: In normal mode, a cycle with `io_wr` high and `io_addr` equal to `PORT_ADDR` (80h) latches `io_data`. Both digits show it from the next cycle, with the upper nibble on `seg_hi` and the lower nibble on `seg_lo`.
- R3: In normal mode, a write whose address differs from `PORT_ADDR` in any bit leaves the digits unchanged.
- R4: Without a further matching write, the latched byte stays on the digits indefinitely.
- R5: Segment bits are active high, with bit 0 = a through bit 6 = g. The patterns for hex values 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R6: In normal mode, `fault_load` high with `io_data` equal to 2Ch, 2Eh or 30h latches the code and `fault_map`. The block then enters fault mode, showing the code with `view_idx` = 0 from the next cycle.
- R7: In normal mode, `fault_load` with any other data byte is ignored, unless the same cycle is also a matching port write.
- R8: In fault mode, each view lasts exactly `DWELL` cycles. The views run in the order code (`view_idx` 0), map bits 15:8 (`view_idx` 1), map bits 7:0 (`view_idx` 2), then back to the code, repeating until reset.
- R9: In fault mode, port writes and further fault loads have no effect on the latched values or on the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O write address |
| io_data | input | 8 | I/O write data / fault checkpoint code |
| io_wr | input | 1 | I/O write strobe |
| fault_load | input | 1 | Loads a fault report from `io_data` and `fault_map` |
| fault_map | input | 16 | Map of failing lines |
| seg_hi | output | 7 | Segments of the upper hex digit (bit 0 = a) |
| seg_lo | output | 7 | Segments of the lower hex digit (bit 0 = a) |
| view_idx | output | 2 | View shown: 0 code, 1 map high byte, 2 map low byte |

## Verification
Every latched value, and every view change, appears on the segment outputs one clock after the edge that causes it, because the digits decode registered state without a further stage. A fault view therefore changes exactly `DWELL` edges after the previous change, counted from the entry edge.

The bench drives inputs just after a rising edge and compares the outputs at the falling edge against a behavioural model that was advanced on that same rising edge. Each result is checked in the cycle it is due. Directed checks also wait a fixed count of edges after each stimulus before sampling.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int SEG_W  = 7;
    localparam int BYTE_W = 8;
    localparam int MAP_W  = 16;

    typedef enum logic [1:0] {
        VIEW_CODE  = 2'd0,
        VIEW_MAPHI = 2'd1,
        VIEW_MAPLO = 2'd2
    } view_e;

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic [MAP_W-1:0]  map;
        logic              fault;
    } disp_state_t;

    function automatic logic is_fault_code(input logic [BYTE_W-1:0] c);
        return (c == 8'h2C) || (c == 8'h2E) || (c == 8'h30);
    endfunction

    function automatic view_e next_view(input view_e v);
        case (v)
            VIEW_CODE:  return VIEW_MAPHI;
            VIEW_MAPHI: return VIEW_MAPLO;
            default:    return VIEW_CODE;
        endcase
    endfunction

    function automatic logic [SEG_W-1:0] hex_to_seg(input logic [3:0] n);
        case (n)
            4'h0: return 7'h3F;
            4'h1: return 7'h06;
            4'h2: return 7'h5B;
            4'h3: return 7'h4F;
            4'h4: return 7'h66;
            4'h5: return 7'h6D;
            4'h6: return 7'h7D;
            4'h7: return 7'h07;
            4'h8: return 7'h7F;
            4'h9: return 7'h6F;
            4'hA: return 7'h77;
            4'hB: return 7'h7C;
            4'hC: return 7'h39;
            4'hD: return 7'h5E;
            4'hE: return 7'h79;
            default: return 7'h71;
        endcase
    endfunction

endpackage

// File: rtl/pcd_bus_decode.sv
module pcd_bus_decode
    import pcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_data,
    input  logic              io_wr,
    input  logic              fault_load,
    input  logic              fault_active,
    output logic              code_wr,
    output logic              fault_enter
);

    logic addr_hit;

    always_comb begin
        addr_hit    = (io_addr == PORT_ADDR);
        fault_enter = !fault_active && fault_load && is_fault_code(io_data);
        code_wr     = !fault_active && !fault_enter && io_wr && addr_hit;
    end

endmodule

// File: rtl/pcd_view_seq.sv
module pcd_view_seq
    import pcd_pkg::*;
#(
    parameter int DWELL = 25_000_000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  active,
    output view_e view
);

    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;
    view_e            view_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q  <= '0;
            view_q <= VIEW_CODE;
        end else if (active) begin
            if (cnt_q == LAST) begin
                cnt_q  <= '0;
                view_q <= next_view(view_q);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign view = view_q;

endmodule

// File: rtl/pcd_byte_seg.sv
module pcd_byte_seg
    import pcd_pkg::*;
#(
    parameter int NIBBLES = 2
) (
    input  logic [4*NIBBLES-1:0]     value,
    output logic [SEG_W*NIBBLES-1:0] segs
);

    for (genvar i = 0; i < NIBBLES; i++) begin : g_digit
        assign segs[SEG_W*i +: SEG_W] = hex_to_seg(value[4*i +: 4]);
    end

endmodule

// File: rtl/post_code_display.sv
module post_code_display
    import pcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
    parameter int DWELL = 25_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_data,
    input  logic              io_wr,
    input  logic              fault_load,
    input  logic [15:0]       fault_map,
    output logic [6:0]        seg_hi,
    output logic [6:0]        seg_lo,
    output logic [1:0]        view_idx
);

    localparam int NIB = BYTE_W / 4;

    disp_state_t       st_q;
    logic              fault_q;
    logic              code_wr;
    logic              fault_enter;
    view_e             view;
    logic [BYTE_W-1:0] shown;
    logic [SEG_W*NIB-1:0] segs;

    assign fault_q = st_q.fault;

    pcd_bus_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
        .io_addr      (io_addr),
        .io_data      (io_data),
        .io_wr        (io_wr),
        .fault_load   (fault_load),
        .fault_active (fault_q),
        .code_wr      (code_wr),
        .fault_enter  (fault_enter)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (fault_enter) begin
            st_q.code  <= io_data;
            st_q.map   <= fault_map;
            st_q.fault <= 1'b1;
        end else if (code_wr) begin
            st_q.code <= io_data;
        end
    end

    pcd_view_seq #(.DWELL(DWELL)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (fault_enter),
        .active (fault_q),
        .view   (view)
    );

    always_comb begin
        case (view)
            VIEW_MAPHI: shown = st_q.map[MAP_W-1 -: BYTE_W];
            VIEW_MAPLO: shown = st_q.map[BYTE_W-1:0];
            default:    shown = st_q.code;
        endcase
    end

    pcd_byte_seg #(.NIBBLES(NIB)) u_seg (
        .value (shown),
        .segs  (segs)
    );

    assign seg_lo   = segs[SEG_W-1:0];
    assign seg_hi   = segs[2*SEG_W-1:SEG_W];
    assign view_idx = view;

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
    parameter int DWELL = 25_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              fault_load,
    input logic              fault_q,
    input logic [6:0]        seg_hi,
    input logic [6:0]        seg_lo,
    input logic [1:0]        view_idx
);

    int unsigned dwell_c;

    always_ff @(posedge clk) begin
        if (rst || !fault_q)            dwell_c <= 0;
        else if (dwell_c == DWELL - 1)  dwell_c <= 0;
        else                            dwell_c <= dwell_c + 1;
    end

    assert_reset_blank_R1: assert property (@(posedge clk)
        rst |=> (seg_hi == 7'h3F && seg_lo == 7'h3F && view_idx == 2'd0 && !fault_q));

    assert_other_addr_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!fault_q && io_wr && !fault_load && io_addr != PORT_ADDR)
        |=> ($stable(seg_hi) && $stable(seg_lo)));

    assert_normal_view_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !fault_q |-> view_idx == 2'd0);

    assert_view_legal_R8: assert property (@(posedge clk) disable iff (rst)
        view_idx != 2'd3);

    assert_view_order_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_q && view_idx != $past(view_idx))
        |-> view_idx == (($past(view_idx) == 2'd2) ? 2'd0 : $past(view_idx) + 2'd1));

    assert_dwell_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_q && dwell_c != DWELL - 1) |=> $stable(view_idx));

    assert_dwell_step_R8: assert property (@(posedge clk) disable iff (rst)
        (fault_q && dwell_c == DWELL - 1) |=> !$stable(view_idx));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);

endmodule

bind post_code_display pcd_checker #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .DWELL(DWELL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .fault_load (fault_load),
    .fault_q    (fault_q),
    .seg_hi     (seg_hi),
    .seg_lo     (seg_lo),
    .view_idx   (view_idx)
);

// File: tb/sim_post_code_display.sv
module sim_post_code_display;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 5;
    localparam int MAX_CYC = 20000;

    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_data = '0;
    logic        io_wr = 0;
    logic        fault_load = 0;
    logic [15:0] fault_map = '0;
    logic [6:0]  seg_hi, seg_lo;
    logic [1:0]  view_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    int m_code = 0, m_map = 0, m_fault = 0, m_view = 0, m_cnt = 0;

    post_code_display #(.ADDR_W(16), .PORT_ADDR(16'h0080), .DWELL(DW)) u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_data(io_data), .io_wr(io_wr),
        .fault_load(fault_load), .fault_map(fault_map),
        .seg_hi(seg_hi), .seg_lo(seg_lo), .view_idx(view_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] seg_of(input int n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n & 15];
    endfunction

    function automatic int shown_byte();
        if (m_view == 1) return (m_map >> 8) & 255;
        if (m_view == 2) return m_map & 255;
        return m_code;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_code = 0; m_map = 0; m_fault = 0; m_view = 0; m_cnt = 0;
        end else if (m_fault == 0) begin
            if (fault_load && (io_data == 8'h2C || io_data == 8'h2E || io_data == 8'h30)) begin
                m_code = io_data; m_map = fault_map; m_fault = 1; m_view = 0; m_cnt = 0;
            end else if (io_wr && io_addr == 16'h0080) begin
                m_code = io_data;
            end
        end else begin
            if (m_cnt == DW - 1) begin
                m_cnt = 0;
                m_view = (m_view + 1) % 3;
            end else begin
                m_cnt++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk({cur_req, " seg_hi"}, int'(seg_hi), int'(seg_of(shown_byte() >> 4)));
            chk({cur_req, " seg_lo"}, int'(seg_lo), int'(seg_of(shown_byte())));
            chk({cur_req, " view_idx"}, int'(view_idx), m_view);
        end
    end

    task automatic port_wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_data = d; io_wr = 1;
        @(posedge clk); #1;
        io_wr = 0;
    endtask

    task automatic load_fault(input logic [7:0] c, input logic [15:0] m, input logic also_wr);
        @(posedge clk); #1;
        io_addr = 16'h0080; io_data = c; fault_map = m; fault_load = 1; io_wr = also_wr;
        @(posedge clk); #1;
        fault_load = 0; io_wr = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst = 1;
        repeat (2) @(posedge clk);
        #1; rst = 0;
    endtask

    task automatic expect_disp(input string req, input logic [7:0] b, input int v);
        @(negedge clk);
        chk({req, " dir seg_hi"}, int'(seg_hi), int'(seg_of(b >> 4)));
        chk({req, " dir seg_lo"}, int'(seg_lo), int'(seg_of(b)));
        chk({req, " dir view"}, int'(view_idx), v);
    endtask

    initial begin : watchdog
        wait (cyc >= MAX_CYC);
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYC);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 0;
        cur_req = "R1";
        expect_disp("R1", 8'h00, 0);

        cur_req = "R2";
        port_wr(16'h0080, 8'h16);
        expect_disp("R2", 8'h16, 0);

        cur_req = "R3";
        port_wr(16'h0081, 8'hA5);
        expect_disp("R3", 8'h16, 0);
        port_wr(16'h0180, 8'h3B);
        expect_disp("R3", 8'h16, 0);

        cur_req = "R4";
        repeat (12) @(posedge clk);
        expect_disp("R4", 8'h16, 0);

        cur_req = "R5";
        for (int n = 0; n < 16; n++) begin
            port_wr(16'h0080, 8'(n * 17));
            expect_disp("R5", 8'(n * 17), 0);
        end

        cur_req = "R7";
        load_fault(8'h16, 16'hFFFF, 1'b0);
        expect_disp("R7", 8'hFF, 0);
        load_fault(8'h2D, 16'h1234, 1'b0);
        repeat (DW + 2) @(posedge clk);
        expect_disp("R7", 8'hFF, 0);

        cur_req = "R6";
        load_fault(8'h2E, 16'h1020, 1'b1);
        expect_disp("R6", 8'h2E, 0);

        cur_req = "R8";
        repeat (DW) @(posedge clk);
        expect_disp("R8", 8'h10, 1);
        repeat (DW) @(posedge clk);
        expect_disp("R8", 8'h20, 2);
        repeat (DW) @(posedge clk);
        expect_disp("R8", 8'h2E, 0);

        cur_req = "R9";
        port_wr(16'h0080, 8'h55);
        load_fault(8'h30, 16'hFFFF, 1'b0);
        repeat (4 * DW) @(posedge clk);
        expect_disp("R9", 8'(m_view == 1 ? 8'h10 : m_view == 2 ? 8'h20 : 8'h2E), m_view);

        cur_req = "R1";
        do_reset();
        expect_disp("R1", 8'h00, 0);

        cur_req = "R6";
        load_fault(8'h2C, 16'h0002, 1'b0);
        expect_disp("R6", 8'h2C, 0);
        cur_req = "R8";
        repeat (7 * DW) @(posedge clk);

        cur_req = "R1";
        do_reset();
        cur_req = "R6";
        load_fault(8'h30, 16'hBEEF, 1'b0);
        expect_disp("R6", 8'h30, 0);
        cur_req = "R8";
        repeat (DW) @(posedge clk);
        expect_disp("R8", 8'hBE, 1);
        repeat (DW) @(posedge clk);
        expect_disp("R8", 8'hEF, 2);
        repeat (5 * DW) @(posedge clk);

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule